// File: doc/BRIEF.md
# Host-DSP Message Doorbell Unit

This unit holds the four 64-bit registers through which a host processor and a DSP core pass message notifications to each other. A host-to-DSP doorbell and a DSP-to-host doorbell each carry a BUSY flag (a message is waiting) and a DONE flag (a message has been handled). Each side also has its own interrupt mask register. Both sides reach every register through their own read port and their own masked write port. A write changes only the bits selected by its mask, so one side can set or clear single flags without a read-modify-write.

Each side gets an interrupt line built from the doorbell flags and that side's mask. Software masks a source while it services it and unmasks it afterwards. The unit also inspects the DSP-to-host doorbell each time the DSP raises BUSY. If the raised word carries the crash signature, the unit reports it together with a 16-bit mailbox offset taken from the word.

Top module: `ipc_doorbell_unit`

## Requirements
- R1: After reset both doorbells read zero, both mask registers read 0x1 (DONE source masked, BUSY source enabled), both interrupt lines are low, panic_valid is 0 and panic_offset is 0.
- R2: The address selects a register: 0 host-to-DSP doorbell, 1 DSP-to-host doorbell, 2 host mask, 3 DSP mask. A write sets each bit whose write-mask bit is 1 to the write-data bit and keeps all other bits. The new value appears on both read ports after the clock edge that takes the write.
- R3: If both sides write the same register in the same cycle, only the host write is applied at that edge. The DSP write is applied at the next edge on top of the register, unless the host writes that register again, in which case it stays held. Writes to different registers in the same cycle all apply at once.
- R4: host_irq is high exactly when (host-to-DSP bit 62 DONE is set and host mask bit 0 is clear) or (DSP-to-host bit 63 BUSY is set and host mask bit 1 is clear).
- R5: dsp_irq is high exactly when (DSP-to-host bit 62 DONE is set and DSP mask bit 0 is clear) or (host-to-DSP bit 63 BUSY is set and DSP mask bit 1 is clear).
- R6: Writing 0x3 into a mask register's low two bits holds that side's interrupt low whatever the doorbells hold.
- R7: When DSP-to-host bit 63 goes from 0 to 1, panic_valid takes the value ((word AND 0x0FFFF000) == 0x0DEAD000) and panic_offset takes word bits 47:32, both from the new word. At all other times both outputs hold their value.
- R8: The message handshakes work in sequence. A host BUSY on its doorbell interrupts the DSP. The DSP's swap of BUSY for DONE interrupts the host once the host has unmasked DONE. A DSP BUSY interrupts the host through the default mask. Setting the matching mask bit drops the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_wr_en | input | 1 | Host write strobe |
| host_addr | input | 2 | Host register select, for both read and write |
| host_wr_mask | input | 64 | Host bit-select for the write |
| host_wr_data | input | 64 | Host write value |
| host_rd_data | output | 64 | Register selected by host_addr |
| dsp_wr_en | input | 1 | DSP write strobe |
| dsp_addr | input | 2 | DSP register select, for both read and write |
| dsp_wr_mask | input | 64 | DSP bit-select for the write |
| dsp_wr_data | input | 64 | DSP write value |
| dsp_rd_data | output | 64 | Register selected by dsp_addr |
| host_irq | output | 1 | Interrupt toward the host |
| dsp_irq | output | 1 | Interrupt toward the DSP |
| panic_valid | output | 1 | Last raised DSP message carried the crash signature |
| panic_offset | output | 16 | Mailbox offset field from the last raised DSP message |

## Verification
The assertions check every cycle that an interrupt never fires without an unmasked source, that a 0x3 mask keeps its line low, that a held DSP write drains on the first edge without a host write to that register, that an untouched register stays stable, and that the panic outputs change only when BUSY rises. The bench scenarios are the only way to show the full handshake order, the deferred value a conflicting DSP write leaves behind, and the signature decode against both matching and non-matching words. Random traffic from both sides is compared against a bench model of the masked-write and hold rules.

// File: rtl/ipc_db_pkg.sv
package ipc_db_pkg;
  localparam int NUM_REGS = 4;
  localparam int ADDR_W   = $clog2(NUM_REGS);

  typedef enum logic [ADDR_W-1:0] {
    REG_H2D  = 2'd0,
    REG_D2H  = 2'd1,
    REG_HMSK = 2'd2,
    REG_DMSK = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/ipc_db_slot.sv
module ipc_db_slot #(
  parameter int              W       = 64,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         host_hit,
  input  logic [W-1:0] host_mask,
  input  logic [W-1:0] host_val,
  input  logic         dsp_hit,
  input  logic [W-1:0] dsp_mask,
  input  logic [W-1:0] dsp_val,
  output logic [W-1:0] q,
  output logic [W-1:0] q_next
);
  logic [W-1:0] pend_m, pend_v, pend_m_n, pend_v_n;
  logic [W-1:0] dm, m_eff, v_eff;
  logic         q_en, p_en;

  // merge the held DSP update with any new one from this cycle
  always_comb begin
    dm    = dsp_hit ? dsp_mask : '0;
    m_eff = pend_m | dm;
    v_eff = (pend_v & ~dm) | (dsp_val & dm);
    if (host_hit) begin
      q_next   = (q & ~host_mask) | (host_val & host_mask);
      pend_m_n = m_eff;
      pend_v_n = v_eff;
    end else begin
      q_next   = (q & ~m_eff) | (v_eff & m_eff);
      pend_m_n = '0;
      pend_v_n = '0;
    end
    q_en = host_hit | (|m_eff);
    p_en = host_hit | (|pend_m);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= RST_VAL;
    end else if (q_en) begin
      q <= q_next;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_m <= '0;
      pend_v <= '0;
    end else if (p_en) begin
      pend_m <= pend_m_n;
      pend_v <= pend_v_n;
    end
  end

  // R3: a held DSP update never outlives an edge without a host write
  p_pend_drain_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !host_hit |=> (pend_m == '0));

  // R2: with no writer and nothing held the register keeps its value
  p_idle_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_hit && !dsp_hit && pend_m == '0) |=> $stable(q));
endmodule

// File: rtl/ipc_db_irq.sv
module ipc_db_irq #(
  parameter int W         = 64,
  parameter int BUSY_BIT  = 63,
  parameter int DONE_BIT  = 62,
  parameter int MDONE_BIT = 0,
  parameter int MBUSY_BIT = 1
) (
  input  logic [W-1:0] done_db,
  input  logic [W-1:0] busy_db,
  input  logic [W-1:0] mask_q,
  output logic         irq
);
  logic done_src, busy_src;

  always_comb begin
    done_src = done_db[DONE_BIT] & ~mask_q[MDONE_BIT];
    busy_src = busy_db[BUSY_BIT] & ~mask_q[MBUSY_BIT];
    irq      = done_src | busy_src;
  end
endmodule

// File: rtl/ipc_db_panic.sv
module ipc_db_panic #(
  parameter int           W        = 64,
  parameter int           BUSY_BIT = 63,
  parameter logic [W-1:0] MAGIC    = 64'h0000_0000_0DEA_D000,
  parameter logic [W-1:0] MMASK    = 64'h0000_0000_0FFF_F000,
  parameter int           OFF_LSB  = 32,
  parameter int           OFF_W    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     cur,
  input  logic [W-1:0]     nxt,
  output logic             valid,
  output logic [OFF_W-1:0] offset
);
  logic             rise;
  logic             valid_n;
  logic [OFF_W-1:0] offset_n;

  always_comb begin
    rise     = nxt[BUSY_BIT] & ~cur[BUSY_BIT];
    valid_n  = ((nxt & MMASK) == MAGIC);
    offset_n = nxt[OFF_LSB +: OFF_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid  <= 1'b0;
      offset <= '0;
    end else if (rise) begin
      valid  <= valid_n;
      offset <= offset_n;
    end
  end

  // R7: on a BUSY rise the offset matches the field of the new word
  p_panic_track_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cur[BUSY_BIT]) |-> (offset == cur[OFF_LSB +: OFF_W]));

  // R7: without a BUSY rise the panic outputs hold
  p_panic_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(cur[BUSY_BIT]) |-> ($stable(offset) && $stable(valid)));
endmodule

// File: rtl/ipc_doorbell_unit.sv
module ipc_doorbell_unit
  import ipc_db_pkg::*;
#(
  parameter int                 DATA_W    = 64,
  parameter int                 BUSY_BIT  = 63,
  parameter int                 DONE_BIT  = 62,
  parameter int                 MDONE_BIT = 0,
  parameter int                 MBUSY_BIT = 1,
  parameter logic [DATA_W-1:0]  PANIC_MAGIC = 64'h0000_0000_0DEA_D000,
  parameter logic [DATA_W-1:0]  PANIC_MMASK = 64'h0000_0000_0FFF_F000,
  parameter int                 OFF_LSB   = 32,
  parameter int                 OFF_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr_en,
  input  logic [1:0]        host_addr,
  input  logic [63:0]       host_wr_mask,
  input  logic [63:0]       host_wr_data,
  output logic [63:0]       host_rd_data,
  input  logic              dsp_wr_en,
  input  logic [1:0]        dsp_addr,
  input  logic [63:0]       dsp_wr_mask,
  input  logic [63:0]       dsp_wr_data,
  output logic [63:0]       dsp_rd_data,
  output logic              host_irq,
  output logic              dsp_irq,
  output logic              panic_valid,
  output logic [15:0]       panic_offset
);
  localparam logic [DATA_W-1:0] MASK_RST = DATA_W'(1) << MDONE_BIT;

  // reset: asserted asynchronously, released after two clean edges
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  logic [NUM_REGS-1:0] host_hit, dsp_hit;
  logic [DATA_W-1:0]   regs_q [NUM_REGS];
  logic [DATA_W-1:0]   regs_n [NUM_REGS];

  always_comb begin
    for (int k = 0; k < NUM_REGS; k++) begin
      host_hit[k] = host_wr_en && (host_addr == ADDR_W'(k));
      dsp_hit[k]  = dsp_wr_en  && (dsp_addr  == ADDR_W'(k));
    end
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
    localparam bit IS_MASK = (i == int'(REG_HMSK)) || (i == int'(REG_DMSK));
    localparam logic [DATA_W-1:0] RV = IS_MASK ? MASK_RST : '0;
    ipc_db_slot #(.W(DATA_W), .RST_VAL(RV)) u_slot (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .host_hit  (host_hit[i]),
      .host_mask (host_wr_mask),
      .host_val  (host_wr_data),
      .dsp_hit   (dsp_hit[i]),
      .dsp_mask  (dsp_wr_mask),
      .dsp_val   (dsp_wr_data),
      .q         (regs_q[i]),
      .q_next    (regs_n[i])
    );
  end

  always_comb begin
    host_rd_data = regs_q[host_addr];
    dsp_rd_data  = regs_q[dsp_addr];
  end

  // host side: reply DONE on its own doorbell, new message BUSY on the other
  ipc_db_irq #(.W(DATA_W), .BUSY_BIT(BUSY_BIT), .DONE_BIT(DONE_BIT),
               .MDONE_BIT(MDONE_BIT), .MBUSY_BIT(MBUSY_BIT)) u_host_irq (
    .done_db (regs_q[REG_H2D]),
    .busy_db (regs_q[REG_D2H]),
    .mask_q  (regs_q[REG_HMSK]),
    .irq     (host_irq)
  );

  // DSP side mirrors the host side
  ipc_db_irq #(.W(DATA_W), .BUSY_BIT(BUSY_BIT), .DONE_BIT(DONE_BIT),
               .MDONE_BIT(MDONE_BIT), .MBUSY_BIT(MBUSY_BIT)) u_dsp_irq (
    .done_db (regs_q[REG_D2H]),
    .busy_db (regs_q[REG_H2D]),
    .mask_q  (regs_q[REG_DMSK]),
    .irq     (dsp_irq)
  );

  ipc_db_panic #(.W(DATA_W), .BUSY_BIT(BUSY_BIT), .MAGIC(PANIC_MAGIC),
                 .MMASK(PANIC_MMASK), .OFF_LSB(OFF_LSB), .OFF_W(OFF_W)) u_panic (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .cur    (regs_q[REG_D2H]),
    .nxt    (regs_n[REG_D2H]),
    .valid  (panic_valid),
    .offset (panic_offset)
  );

  // R4: the host line never fires without an unmasked source
  p_host_src_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    host_irq |-> ((regs_q[REG_H2D][DONE_BIT] && !regs_q[REG_HMSK][MDONE_BIT]) ||
                  (regs_q[REG_D2H][BUSY_BIT] && !regs_q[REG_HMSK][MBUSY_BIT])));

  // R5: the DSP line never fires without an unmasked source
  p_dsp_src_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    dsp_irq |-> ((regs_q[REG_D2H][DONE_BIT] && !regs_q[REG_DMSK][MDONE_BIT]) ||
                 (regs_q[REG_H2D][BUSY_BIT] && !regs_q[REG_DMSK][MBUSY_BIT])));

  // R6: both mask bits set silences the line
  p_host_silent_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (regs_q[REG_HMSK][MDONE_BIT] && regs_q[REG_HMSK][MBUSY_BIT]) |-> !host_irq);
  p_dsp_silent_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (regs_q[REG_DMSK][MDONE_BIT] && regs_q[REG_DMSK][MBUSY_BIT]) |-> !dsp_irq);
endmodule

// File: tb/ipc_doorbell_unit_tb_top.sv
`timescale 1ns/1ps
module ipc_doorbell_unit_tb_top;
  localparam int BUSY = 63;
  localparam int DONE = 62;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_wr_en, dsp_wr_en;
  logic [1:0]  host_addr, dsp_addr;
  logic [63:0] host_wr_mask, host_wr_data, dsp_wr_mask, dsp_wr_data;
  logic [63:0] host_rd_data, dsp_rd_data;
  logic        host_irq, dsp_irq, panic_valid;
  logic [15:0] panic_offset;

  always #2 clk = ~clk;

  ipc_doorbell_unit dut_i (
    .clk(clk), .rst_n(rst_n),
    .host_wr_en(host_wr_en), .host_addr(host_addr),
    .host_wr_mask(host_wr_mask), .host_wr_data(host_wr_data),
    .host_rd_data(host_rd_data),
    .dsp_wr_en(dsp_wr_en), .dsp_addr(dsp_addr),
    .dsp_wr_mask(dsp_wr_mask), .dsp_wr_data(dsp_wr_data),
    .dsp_rd_data(dsp_rd_data),
    .host_irq(host_irq), .dsp_irq(dsp_irq),
    .panic_valid(panic_valid), .panic_offset(panic_offset)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [63:0] mq [4];
  logic [63:0] mpm [4];
  logic [63:0] mpv [4];
  logic        e_pv;
  logic [15:0] e_po;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic exp_host_irq();
    return (mq[0][DONE] & ~mq[2][0]) | (mq[1][BUSY] & ~mq[2][1]);
  endfunction

  function automatic logic exp_dsp_irq();
    return (mq[1][DONE] & ~mq[3][0]) | (mq[0][BUSY] & ~mq[3][1]);
  endfunction

  task automatic model_reset();
    mq[0] = '0; mq[1] = '0; mq[2] = 64'h1; mq[3] = 64'h1;
    for (int r = 0; r < 4; r++) begin mpm[r] = '0; mpv[r] = '0; end
    e_pv = 1'b0; e_po = '0;
  endtask

  task automatic idle();
    host_wr_en = 0; dsp_wr_en = 0;
    host_wr_mask = '0; host_wr_data = '0;
    dsp_wr_mask = '0; dsp_wr_data = '0;
  endtask

  task automatic check_all();
    chk("R2 host read", host_rd_data, mq[host_addr]);
    chk("R2 dsp read", dsp_rd_data, mq[dsp_addr]);
    chk("R4 host_irq", 64'(host_irq), 64'(exp_host_irq()));
    chk("R5 dsp_irq", 64'(dsp_irq), 64'(exp_dsp_irq()));
    chk("R7 panic_valid", 64'(panic_valid), 64'(e_pv));
    chk("R7 panic_offset", 64'(panic_offset), 64'(e_po));
  endtask

  // model the edge, take it, then compare
  task automatic tick();
    logic [63:0] nq [4];
    logic [63:0] npm [4];
    logic [63:0] npv [4];
    for (int r = 0; r < 4; r++) begin
      logic hh, dh;
      logic [63:0] dm, me, ve;
      hh = host_wr_en && (host_addr == 2'(r));
      dh = dsp_wr_en && (dsp_addr == 2'(r));
      dm = dh ? dsp_wr_mask : '0;
      me = mpm[r] | dm;
      ve = (mpv[r] & ~dm) | (dsp_wr_data & dm);
      if (hh) begin
        nq[r] = (mq[r] & ~host_wr_mask) | (host_wr_data & host_wr_mask);
        npm[r] = me; npv[r] = ve;
      end else begin
        nq[r] = (mq[r] & ~me) | (ve & me);
        npm[r] = '0; npv[r] = '0;
      end
    end
    if (nq[1][BUSY] && !mq[1][BUSY]) begin
      e_pv = ((nq[1] & 64'h0FFF_F000) == 64'h0DEA_D000);
      e_po = nq[1][47:32];
    end
    @(posedge clk);
    #1;
    for (int r = 0; r < 4; r++) begin mq[r] = nq[r]; mpm[r] = npm[r]; mpv[r] = npv[r]; end
    check_all();
  endtask

  task automatic hw(input logic [1:0] a, input logic [63:0] m, input logic [63:0] d);
    idle(); host_wr_en = 1; host_addr = a; host_wr_mask = m; host_wr_data = d;
    tick(); idle();
  endtask

  task automatic dw(input logic [1:0] a, input logic [63:0] m, input logic [63:0] d);
    idle(); dsp_wr_en = 1; dsp_addr = a; dsp_wr_mask = m; dsp_wr_data = d;
    tick(); idle();
  endtask

  localparam logic [63:0] B_BUSY = 64'h1 << BUSY;
  localparam logic [63:0] B_DONE = 64'h1 << DONE;

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'h5EED_1234);
    rst_n = 0; idle(); host_addr = 0; dsp_addr = 0;
    model_reset();
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    repeat (3) @(posedge clk);
    #1;

    // R1 reset state
    for (int r = 0; r < 4; r++) begin
      host_addr = 2'(r); #0.5;
      chk("R1 reset value", host_rd_data, (r >= 2) ? 64'h1 : 64'h0);
    end
    chk("R1 host_irq low", 64'(host_irq), 64'h0);
    chk("R1 dsp_irq low", 64'(dsp_irq), 64'h0);
    chk("R1 panic_valid", 64'(panic_valid), 64'h0);
    chk("R1 panic_offset", 64'(panic_offset), 64'h0);
    host_addr = 0; dsp_addr = 0;

    // R8 host to DSP handshake
    hw(2, 64'h1, 64'h0);                 // unmask DONE on host side
    hw(0, B_BUSY, B_BUSY);
    chk("R8 dsp_irq on host BUSY", 64'(dsp_irq), 64'h1);
    dw(3, 64'h2, 64'h2);                 // DSP masks BUSY source
    chk("R8 dsp_irq masked", 64'(dsp_irq), 64'h0);
    dw(0, B_BUSY | B_DONE, B_DONE);
    chk("R8 host_irq on reply", 64'(host_irq), 64'h1);
    hw(2, 64'h1, 64'h1);
    chk("R8 host_irq masked", 64'(host_irq), 64'h0);
    hw(0, B_DONE, 64'h0);
    host_addr = 0; #0.5;
    chk("R8 doorbell idle", host_rd_data, 64'h0);
    dw(3, 64'h2, 64'h0);

    // R8 DSP to host handshake, with R7 panic signature
    dw(1, B_BUSY | 64'h0000_FFFF_FFFF_FFFF, B_BUSY | 64'h0000_0123_0DEA_D000);
    chk("R8 host_irq on DSP BUSY", 64'(host_irq), 64'h1);
    chk("R7 panic detected", 64'(panic_valid), 64'h1);
    chk("R7 panic offset", 64'(panic_offset), 64'h0123);
    hw(2, 64'h2, 64'h2);
    chk("R8 host_irq masked busy", 64'(host_irq), 64'h0);
    dw(1, 64'h0000_FFFF_0000_0000, 64'h0000_0BAD_0000_0000); // BUSY stays set
    chk("R7 no update without rise", 64'(panic_offset), 64'h0123);
    hw(1, B_BUSY | B_DONE, B_DONE);
    hw(2, 64'h2, 64'h0);
    dw(1, 64'hFFFF_FFFF_FFFF_FFFF, B_BUSY | 64'h0000_0042_0000_0005);
    chk("R7 plain message clears valid", 64'(panic_valid), 64'h0);
    chk("R7 plain offset", 64'(panic_offset), 64'h0042);

    // R3 same-register conflict
    hw(0, 64'hFFFF, 64'h0);
    idle();
    host_wr_en = 1; host_addr = 0; host_wr_mask = 64'hFF; host_wr_data = 64'hAA;
    dsp_wr_en = 1; dsp_addr = 0; dsp_wr_mask = 64'hFF00; dsp_wr_data = 64'h5500;
    tick(); idle();
    chk("R3 host first", host_rd_data & 64'hFFFF, 64'h00AA);
    host_addr = 0; tick();
    chk("R3 dsp next edge", host_rd_data & 64'hFFFF, 64'h55AA);
    // R3 different registers in the same cycle
    host_wr_en = 1; host_addr = 2; host_wr_mask = 64'hF0; host_wr_data = 64'h30;
    dsp_wr_en = 1; dsp_addr = 3; dsp_wr_mask = 64'hF0; dsp_wr_data = 64'h50;
    tick(); idle();
    chk("R3 host reg applied", host_rd_data & 64'hF0, 64'h30);
    chk("R3 dsp reg applied", dsp_rd_data & 64'hF0, 64'h50);

    // R6 full mask silences both lines
    hw(0, B_BUSY | B_DONE, B_BUSY | B_DONE);
    hw(1, B_BUSY | B_DONE, B_BUSY | B_DONE);
    hw(2, 64'h3, 64'h3);
    dw(3, 64'h3, 64'h3);
    chk("R6 host silent", 64'(host_irq), 64'h0);
    chk("R6 dsp silent", 64'(dsp_irq), 64'h0);

    // random traffic from both sides
    for (int n = 0; n < 3000; n++) begin
      logic [63:0] rm, rd, dmsk, ddat;
      rm = {$urandom, $urandom}; rd = {$urandom, $urandom};
      dmsk = {$urandom, $urandom}; ddat = {$urandom, $urandom};
      if ($urandom_range(0, 3) == 0) begin rm = B_BUSY | B_DONE | 64'h3; end
      if ($urandom_range(0, 3) == 0) begin dmsk = B_BUSY | B_DONE | 64'h3; end
      if ($urandom_range(0, 7) == 0) begin ddat[31:0] = 32'h0DEA_D000; end
      host_wr_en = ($urandom_range(0, 2) == 0);
      dsp_wr_en  = ($urandom_range(0, 2) == 0);
      host_addr = 2'($urandom_range(0, 3));
      dsp_addr  = 2'($urandom_range(0, 3));
      host_wr_mask = rm; host_wr_data = rd;
      dsp_wr_mask = dmsk; dsp_wr_data = ddat;
      tick();
    end
    idle(); tick(); tick();

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule